// File: doc/BRIEF.md
# Misaligned Load/Store Bus Splitter

This block sits between a load/store requester and a little-endian memory bus whose data path is eight bytes wide and carries one enable per byte. The requester asks for a read or a write of 1, 2, 4 or 8 bytes at any byte address. The block decides whether the access fits in one bus cycle or needs two. It drives each bus cycle with an 8-byte-aligned address and a byte-enable mask. For writes, it moves the data bytes into their lanes. For reads, it assembles the returned bytes into one right-justified, zero-extended result.

The rule for splitting depends on the operand size. A 2-byte or 4-byte operand is split when its bytes straddle a 4-byte group boundary. This can happen even inside one 8-byte window, and in that case both bus cycles use the same address with different enables. An 8-byte operand is split only when it straddles an 8-byte boundary. Both sides use a valid/ready handshake, and bus responses arrive as a one-cycle pulse.

The controller has six states:
- `ST_IDLE` takes a request (transition *accept*) and moves to `ST_ISSUE_LO`.
- `ST_ISSUE_LO` offers the lower part and moves on *bus grant* to `ST_WAIT_LO`.
- `ST_WAIT_LO` waits for the response. On *response, split* it goes to `ST_ISSUE_HI`. On *response, whole* it goes to `ST_RESPOND`.
- `ST_ISSUE_HI` offers the upper part and moves on *bus grant* to `ST_WAIT_HI`.
- `ST_WAIT_HI` goes to `ST_RESPOND` on *response*.
- `ST_RESPOND` holds the completion until *taken*, then returns to `ST_IDLE`.

Top module: `split_access_unit`

## Requirements
- R1: A bus cycle's address always has its low three bits at zero. Its enable mask has bit n set exactly for each lane n that the operand occupies in that 8-byte window. An access that needs no split uses exactly one bus cycle.
- R2: A 2-byte (size code 01) or 4-byte (size code 10) access whose bytes straddle a 4-byte boundary is done as two bus cycles. The first covers the lower-addressed bytes and the second covers the rest. When both parts lie in one 8-byte window, both cycles carry the same address.
- R3: An 8-byte access (size code 11) uses two bus cycles exactly when its address is not a multiple of 8. The first cycle covers the lower window and the second covers the next window, at address +8.
- R4: A 2-byte access at an odd address that stays inside one 4-byte group completes in one bus cycle.
- R5: For writes, operand byte k is driven in lane (address + k) mod 8 of every cycle. Lanes that are not enabled are driven as zero. Operand bytes above the size are never written to memory.
- R6: The read result is little-endian and right-justified: result byte k is the memory byte at address + k. Bytes above the operand size read as zero. Size code 00 selects one byte.
- R7: The requester sees exactly one completion, and only after the last bus cycle's response. The completion and its data hold until the requester takes it.
- R8: A new request is taken only in `ST_IDLE`. While a bus cycle is offered and not yet granted, its address, enables and data hold steady.
- R9: After reset, the block is ready for a request and no bus cycle or completion is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 two bytes, 10 four bytes, 11 eight bytes |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 8*LANES | Write operand, right-justified |
| resp_valid | output | 1 | Completion present |
| resp_ready | input | 1 | Requester takes the completion |
| resp_rdata | output | 8*LANES | Read result, zero-extended (zero for writes) |
| bus_valid | output | 1 | Bus cycle offered |
| bus_ready | input | 1 | Bus grants the cycle |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Window-aligned bus address |
| bus_be | output | LANES | Per-lane byte enables |
| bus_wdata | output | 8*LANES | Lane-steered write data |
| bus_rsp_valid | input | 1 | One-cycle response pulse for the granted cycle |
| bus_rdata | input | 8*LANES | Read data for the response |

## Verification
The bench builds the block with ADDR_W = 32, LANES = 8 and SUB_GROUP = 4. It covers these access patterns:
- A 2-byte access at offset 3 that splits inside one window.
- A 4-byte write that splits across windows.
- An 8-byte access at offset 4 that splits even though no 4-byte group is crossed.
- An odd 2-byte access at offset 1 that stays whole.

A 64-byte memory model makes the split write and its read-back observable. Grant and completion stalls exercise the hold rules.

// File: rtl/split_pkg.sv
package split_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LO,
        ST_WAIT_LO,
        ST_ISSUE_HI,
        ST_WAIT_HI,
        ST_RESPOND
    } state_e;

endpackage

// File: rtl/split_planner.sv
module split_planner
    import split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LANES     = 8,
    parameter int SUB_GROUP = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  size_e             size,
    output logic              is_split,
    output logic [ADDR_W-1:0] addr_lo,
    output logic [LANES-1:0]  be_lo,
    output logic [ADDR_W-1:0] addr_hi,
    output logic [LANES-1:0]  be_hi
);
    localparam int OFS_W = $clog2(LANES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LANES);

    logic [2*LANES-1:0] span;
    int ofs_i, nb_i, grp_i, bnd_i;

    always_comb begin
        ofs_i = int'(addr[OFS_W-1:0]);
        nb_i  = 1 << int'(size);
        grp_i = (size == SZ_QWORD) ? LANES : SUB_GROUP;
        bnd_i = (ofs_i / grp_i) * grp_i + grp_i;
        for (int i = 0; i < 2*LANES; i++) begin
            span[i] = (i >= ofs_i) && (i < ofs_i + nb_i);
        end
        is_split = (ofs_i + nb_i) > bnd_i;
        addr_lo  = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        for (int i = 0; i < LANES; i++) begin
            be_lo[i] = span[i] && (i < bnd_i);
        end
        if (bnd_i >= LANES) begin
            addr_hi = addr_lo + STEP;
            for (int i = 0; i < LANES; i++) be_hi[i] = span[i+LANES];
        end else begin
            addr_hi = addr_lo;
            for (int i = 0; i < LANES; i++) be_hi[i] = span[i] && (i >= bnd_i);
        end
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
    parameter int LANES = 8
) (
    input  logic [$clog2(LANES)-1:0] ofs,
    input  logic [LANES-1:0]         be,
    input  logic [8*LANES-1:0]       din,
    output logic [8*LANES-1:0]       dout
);
    int ofs_i;
    always_comb begin
        ofs_i = int'(ofs);
        for (int j = 0; j < LANES; j++) begin
            dout[j*8 +: 8] = be[j] ? din[((j - ofs_i + LANES) % LANES)*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/read_gather.sv
module read_gather
    import split_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [$clog2(LANES)-1:0] ofs,
    input  size_e                    size,
    input  logic [8*LANES-1:0]       hold,
    output logic [8*LANES-1:0]       result
);
    int ofs_i, nb_i;
    always_comb begin
        ofs_i = int'(ofs);
        nb_i  = 1 << int'(size);
        for (int k = 0; k < LANES; k++) begin
            result[k*8 +: 8] = (k < nb_i) ? hold[((ofs_i + k) % LANES)*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/split_access_unit.sv
module split_access_unit
    import split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LANES     = 8,
    parameter int SUB_GROUP = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_we,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [8*LANES-1:0]   req_wdata,
    output logic                 resp_valid,
    input  logic                 resp_ready,
    output logic [8*LANES-1:0]   resp_rdata,
    output logic                 bus_valid,
    input  logic                 bus_ready,
    output logic                 bus_we,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [LANES-1:0]     bus_be,
    output logic [8*LANES-1:0]   bus_wdata,
    input  logic                 bus_rsp_valid,
    input  logic [8*LANES-1:0]   bus_rdata
);
    localparam int OFS_W  = $clog2(LANES);
    localparam int DATA_W = 8 * LANES;

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    size_e               size_q;
    logic                we_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   hold_q;

    logic                is_split;
    logic [ADDR_W-1:0]   addr_lo, addr_hi;
    logic [LANES-1:0]    be_lo, be_hi, cur_be;
    logic [DATA_W-1:0]   gathered;

    split_planner #(.ADDR_W(ADDR_W), .LANES(LANES), .SUB_GROUP(SUB_GROUP)) planner_i (
        .addr(addr_q), .size(size_q), .is_split(is_split),
        .addr_lo(addr_lo), .be_lo(be_lo), .addr_hi(addr_hi), .be_hi(be_hi)
    );

    lane_steer #(.LANES(LANES)) steer_i (
        .ofs(addr_q[OFS_W-1:0]), .be(bus_be), .din(wdata_q), .dout(bus_wdata)
    );

    read_gather #(.LANES(LANES)) gather_i (
        .ofs(addr_q[OFS_W-1:0]), .size(size_q), .hold(hold_q), .result(gathered)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_d = ST_ISSUE_LO;
            ST_ISSUE_LO: if (bus_ready)     state_d = ST_WAIT_LO;
            ST_WAIT_LO:  if (bus_rsp_valid) state_d = is_split ? ST_ISSUE_HI : ST_RESPOND;
            ST_ISSUE_HI: if (bus_ready)     state_d = ST_WAIT_HI;
            ST_WAIT_HI:  if (bus_rsp_valid) state_d = ST_RESPOND;
            ST_RESPOND:  if (resp_ready)    state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        bus_valid  = 1'b0;
        bus_addr   = '0;
        cur_be     = '0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_ISSUE_LO: begin bus_valid = 1'b1; bus_addr = addr_lo; cur_be = be_lo; end
            ST_WAIT_LO:  cur_be = be_lo;
            ST_ISSUE_HI: begin bus_valid = 1'b1; bus_addr = addr_hi; cur_be = be_hi; end
            ST_WAIT_HI:  cur_be = be_hi;
            ST_RESPOND:  resp_valid = 1'b1;
            default:     req_ready = 1'b0;
        endcase
        bus_be     = bus_valid ? cur_be : '0;
        bus_we     = bus_valid & we_q;
        resp_rdata = we_q ? '0 : gathered;
    end

    // Captured request and read holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            we_q    <= 1'b0;
            wdata_q <= '0;
            hold_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            size_q  <= size_e'(req_size);
            we_q    <= req_we;
            wdata_q <= req_wdata;
            hold_q  <= '0;
        end else if ((state_q == ST_WAIT_LO || state_q == ST_WAIT_HI) && bus_rsp_valid) begin
            for (int j = 0; j < LANES; j++) begin
                if (cur_be[j]) hold_q[j*8 +: 8] <= bus_rdata[j*8 +: 8];
            end
        end
    end

    // Assertions
    assert_bus_addr_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_addr[OFS_W-1:0] == '0));

    assert_bus_be_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_be != '0));

    assert_parts_cover_operand_R2: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> ((is_split ? ($countones(be_lo) + $countones(be_hi)) : $countones(be_lo))
                        == (1 << int'(size_q))));

    assert_hi_not_below_lo_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ISSUE_HI) |-> (bus_addr >= addr_lo));

    assert_resp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata)));

    assert_bus_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                       && $stable(bus_be) && $stable(bus_wdata)));

    assert_busy_blocks_request_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid || resp_valid) |-> !req_ready);
endmodule

// File: tb/split_access_unit_tb_top.sv
`timescale 1ns/1ps
module split_access_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_we = 1'b0, resp_ready = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        bus_ready = 1'b0, bus_rsp_valid = 1'b0;
    logic [63:0] bus_rdata = '0;
    logic        req_ready, resp_valid, bus_valid, bus_we;
    logic [63:0] resp_rdata, bus_wdata;
    logic [31:0] bus_addr;
    logic [7:0]  bus_be;

    always #4 clk = ~clk;

    split_access_unit dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rdata(bus_rdata)
    );

    int n_checks = 0, n_fail = 0;
    logic [7:0]  mem [0:63];
    int          rec_n;
    logic [31:0] rec_addr [0:3];
    logic [7:0]  rec_be   [0:3];
    logic [63:0] rec_wd   [0:3];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] window(input logic [31:0] a);
        logic [63:0] w;
        for (int i = 0; i < 8; i++) w[i*8 +: 8] = mem[(int'(a[5:0]) + i) % 64];
        return w;
    endfunction

    task automatic run_access(input logic we, input logic [1:0] sz, input logic [31:0] a,
                              input logic [63:0] wd, input int bstall, input int rstall,
                              output logic [63:0] rd);
        int guard = 0, stall = bstall;
        logic done = 1'b0;
        logic [31:0] last_a = '0;
        rd = '0;
        rec_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
            bus_rsp_valid = 1'b0;
            if (bus_ready) begin
                bus_ready = 1'b0;
                bus_rsp_valid = 1'b1;
                bus_rdata = window(last_a);
            end else if (bus_valid) begin
                if (stall > 0) stall--;
                else begin
                    if (rec_n < 4) begin
                        rec_addr[rec_n] = bus_addr; rec_be[rec_n] = bus_be; rec_wd[rec_n] = bus_wdata;
                    end
                    rec_n++;
                    if (bus_we)
                        for (int i = 0; i < 8; i++)
                            if (bus_be[i]) mem[(int'(bus_addr[5:0]) + i) % 64] = bus_wdata[i*8 +: 8];
                    last_a = bus_addr;
                    bus_ready = 1'b1;
                    stall = bstall;
                end
            end
            if (resp_valid) begin
                logic [63:0] first = resp_rdata;
                for (int s = 0; s < rstall; s++) @(negedge clk);
                if (rstall > 0) begin
                    check("R7 completion held", {63'd0, resp_valid}, 64'd1);
                    check("R7 completion data held", resp_rdata, first);
                    check("R8 no request taken while busy", {63'd0, req_ready}, 64'd0);
                end
                rd = resp_rdata;
                resp_ready = 1'b1;
                @(negedge clk);
                resp_ready = 1'b0;
                done = 1'b1;
            end
        end
        if (!done) check("R7 access completion (watchdog)", 64'd0, 64'd1);
    endtask

    task automatic t_reset;
        check("R9 req_ready after reset", {63'd0, req_ready}, 64'd1);
        check("R9 bus_valid after reset", {63'd0, bus_valid}, 64'd0);
        check("R9 resp_valid after reset", {63'd0, resp_valid}, 64'd0);
    endtask

    task automatic t_word_split_same_window;
        logic [63:0] rd;
        run_access(1'b0, 2'b01, 32'h0B, '0, 0, 0, rd);
        check("R2 two cycles", 64'(rec_n), 64'd2);
        check("R2 first addr", 64'(rec_addr[0]), 64'h08);
        check("R2 first be", 64'(rec_be[0]), 64'h08);
        check("R2 second addr same window", 64'(rec_addr[1]), 64'h08);
        check("R2 second be", 64'(rec_be[1]), 64'h10);
        check("R6 word at 0Bh", rd, 64'hFE06);
    endtask

    task automatic t_qword_cross;
        logic [63:0] rd;
        run_access(1'b0, 2'b11, 32'h06, '0, 0, 0, rd);
        check("R3 two cycles", 64'(rec_n), 64'd2);
        check("R3 first addr/be", {24'd0, rec_addr[0], rec_be[0]}, {24'd0, 32'h00, 8'hC0});
        check("R3 second addr/be", {24'd0, rec_addr[1], rec_be[1]}, {24'd0, 32'h08, 8'h3F});
        check("R6 quadword at 06h", rd, 64'h7AFE06361FA4230B);
    endtask

    task automatic t_word_odd_inside;
        logic [63:0] rd;
        run_access(1'b0, 2'b01, 32'h01, '0, 0, 0, rd);
        check("R4 one cycle", 64'(rec_n), 64'd1);
        check("R4 addr/be", {24'd0, rec_addr[0], rec_be[0]}, {24'd0, 32'h00, 8'h06});
        check("R4 data", rd, 64'h110A);
    endtask

    task automatic t_aligned;
        logic [63:0] rd;
        run_access(1'b0, 2'b10, 32'h10, '0, 0, 0, rd);
        check("R1 dword one cycle", 64'(rec_n), 64'd1);
        check("R1 dword addr/be", {24'd0, rec_addr[0], rec_be[0]}, {24'd0, 32'h10, 8'h0F});
        check("R6 dword data", rd, 64'h88817A73);
        run_access(1'b0, 2'b00, 32'h17, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, rd);
        check("R1 byte addr/be", {24'd0, rec_addr[0], rec_be[0]}, {24'd0, 32'h10, 8'h80});
        check("R6 byte zero-extended", rd, 64'hA4);
    endtask

    task automatic t_write_split;
        logic [63:0] rd;
        run_access(1'b1, 2'b10, 32'h1E, 64'h12345678_DEADBEEF, 0, 0, rd);
        check("R2 write two cycles", 64'(rec_n), 64'd2);
        check("R5 first addr/be", {24'd0, rec_addr[0], rec_be[0]}, {24'd0, 32'h18, 8'hC0});
        check("R5 first lanes", rec_wd[0], 64'hBEEF_0000_0000_0000);
        check("R5 second addr/be", {24'd0, rec_addr[1], rec_be[1]}, {24'd0, 32'h20, 8'h03});
        check("R5 second lanes", rec_wd[1], 64'h0000_0000_0000_DEAD);
        run_access(1'b0, 2'b10, 32'h1E, '0, 0, 0, rd);
        check("R5 read back", rd, 64'hDEADBEEF);
        run_access(1'b0, 2'b01, 32'h1D, '0, 0, 0, rd);
        check("R5 byte below untouched", rd, 64'hEFCE);
        run_access(1'b0, 2'b00, 32'h22, '0, 0, 0, rd);
        check("R5 byte above untouched", rd, 64'hF1);
    endtask

    task automatic t_qword_mid;
        logic [63:0] rd;
        run_access(1'b0, 2'b11, 32'h04, '0, 0, 0, rd);
        check("R3 offset-4 quadword splits", 64'(rec_n), 64'd2);
        check("R3 first addr/be", {24'd0, rec_addr[0], rec_be[0]}, {24'd0, 32'h00, 8'hF0});
        check("R3 second addr/be", {24'd0, rec_addr[1], rec_be[1]}, {24'd0, 32'h08, 8'h0F});
        check("R6 quadword at 04h", rd, 64'h06361FA4230B261F);
        run_access(1'b1, 2'b11, 32'h28, 64'h01020304_05060708, 0, 0, rd);
        check("R1 aligned quadword one cycle", 64'(rec_n), 64'd1);
        check("R1 aligned quadword be", 64'(rec_be[0]), 64'hFF);
        check("R5 aligned quadword lanes", rec_wd[0], 64'h01020304_05060708);
    endtask

    task automatic t_stall;
        logic [63:0] rd;
        run_access(1'b0, 2'b01, 32'h0B, '0, 2, 3, rd);
        check("R8 stalled split still two cycles", 64'(rec_n), 64'd2);
        check("R7 stalled data", rd, 64'hFE06);
    endtask

    logic finished = 1'b0;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        mem[6] = 8'h0B; mem[7] = 8'h23; mem[8] = 8'hA4; mem[9] = 8'h1F;
        mem[10] = 8'h36; mem[11] = 8'h06; mem[12] = 8'hFE; mem[13] = 8'h7A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word_split_same_window();
        t_qword_cross();
        t_word_odd_inside();
        t_aligned();
        t_write_split();
        t_qword_mid();
        t_stall();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule